// File: doc/BRIEF.md
# Pixel-Doubling Monochrome Raster Scan-Out

This block turns a 512x342 one-bit-per-pixel image held in a 16-bit-wide shared RAM into a 1024x768, 60 Hz raster. The raster runs from a 65 MHz pixel clock. Every stored pixel is shown as a 2x2 block of output pixels. The doubled image spans the full visible width. Vertically it occupies 684 of the 768 visible lines, with 42 blank lines above and 42 below.

The RAM is shared with a processor that runs at one eighth of the pixel clock. Access alternates in fixed windows of 32 pixel clocks (four processor clocks): one processor window, then one video window. In each video window the block issues two back-to-back word reads, 32 stored pixels in all, into a holding register. That register is handed to a shift buffer exactly when the previous 64 output pixels have been shown. Each stored line is fetched twice, once for each of its two output lines, from the same base address. The processor side of the bus and any analog output stage sit outside this block.

The column and line counters drive the RAM request outputs (`ramRd`, `ramAddr`, `cpuSlot`) directly. The raster outputs (`hsyncN`, `vsyncN`, `videoOut`) pass through one register, so they show column c one clock after the request outputs show column c. The RAM returns the word one clock after the read strobe.

Top module: `monoScanout`

## Requirements
- R1: A line lasts 1344 clocks: columns 0..1023 visible, then 24 front porch, 136 sync and 160 back porch. `hsyncN` is low exactly for columns 1048..1183.
- R2: A frame lasts 806 lines: lines 0..767 visible, then 3 front porch, 6 sync and 29 back porch. `vsyncN` is low exactly for lines 771..776 (in general, V_VIS+V_FP up to V_VIS+V_FP+V_SYNC-1).
- R3: `cpuSlot` is high when (column mod 64) < 32 and low otherwise, on every line. `ramRd` is never high while `cpuSlot` is high.
- R4: Reads occur only in pairs, at the columns where (column mod 64) equals 32 and 33, and `ramAddr` rises by one from the first read to the second. Column group g (output columns 64g..64g+63) is fetched in the video window of group g-1. Group 0 of a line is fetched in the last window (columns 1280..1343) of the line before it.
- R5: On line v, the count of clocks with `ramRd` high is 30 if v shows image rows, plus 2 if line v+1 (modulo the frame) shows image rows.
- R6: The word address for output line v, column group g and read k (0 or 1) is row*32 + 2g + k, where row = (v-42)/2. Both output lines of an image row therefore read the same addresses.
- R7: Within a 32-bit fetch the first word supplies the left 16 pixels. Bits are shown from most significant to least significant, each for two clocks. A set bit shows as black (`videoOut` = 0) and a clear bit as white (`videoOut` = 1).
- R8: Output lines 42..725 show image rows 0..341, each row on two consecutive lines. Visible lines 0..41 and 726..767 stay black.
- R9: `videoOut` is 0 on every column or line outside the visible area.
- R10: While `rst` is high, `hsyncN` and `vsyncN` are 1, `videoOut` is 0, `ramRd` is 0 and `cpuSlot` is 1. The first clock after reset is column 0 of line 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock, 65 MHz |
| rst | input | 1 | Synchronous reset, active high |
| ramData | input | DATA_W | Word returned by the RAM one clock after a read |
| ramRd | output | 1 | Read strobe to the shared RAM |
| ramAddr | output | ADDR_W | Word address of the current read |
| cpuSlot | output | 1 | High while the processor owns the RAM |
| hsyncN | output | 1 | Horizontal sync, active low |
| vsyncN | output | 1 | Vertical sync, active low |
| videoOut | output | 1 | Mono pixel, 1 = white, 0 = black |

## Verification
The bench keeps the full horizontal timing but shrinks the vertical parameters. That lets several whole frames, including sync, wrap and the letterbox bands, fit the run. The RAM model returns a different pattern each frame, in this order:
- A seeded hash of the address, which exposes any wrong word or bit.
- A word with only its end bits set, which pins down the MSB-first order and the two-clock doubling.
- The address folded into the data, which separates the first and second read of a pair and the base address of each row.
- All-clear words, which give a white window with sharp edges against the black bands.

Read counts per line and the exact read addresses are checked on every line. This catches a missing prefetch on the line before the image, and a stray fetch on the line after it.

// File: rtl/monoScanoutPkg.sv
package monoScanoutPkg;

  // Per-clock strobes from the timing controller to the pixel datapath.
  typedef struct packed {
    logic capHi;    // ramData holds the first (left) word of a pair
    logic capLo;    // ramData holds the second (right) word of a pair
    logic loadBuf;  // first clock of a 64-column group
    logic shiftBuf; // odd column: advance to the next stored pixel
    logic pixOn;    // column and line lie inside the image window
    logic hsyncN;   // raw horizontal sync for the current column
    logic vsyncN;   // raw vertical sync for the current line
  } ctrlStrobes_t;

endpackage

// File: rtl/scanCtrl.sv
module scanCtrl
  import monoScanoutPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 14,
  parameter int SRC_W  = 512,
  parameter int SRC_H  = 342,
  parameter int H_VIS  = 1024,
  parameter int H_FP   = 24,
  parameter int H_SYNC = 136,
  parameter int H_BP   = 160,
  parameter int V_VIS  = 768,
  parameter int V_FP   = 3,
  parameter int V_SYNC = 6,
  parameter int V_BP   = 29
) (
  input  logic                clk,
  input  logic                rst,
  output logic                ramRd,
  output logic [ADDR_W-1:0]   ramAddr,
  output logic                cpuSlot,
  output ctrlStrobes_t        strb
);

  localparam int H_TOTAL     = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL     = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int HC_W        = $clog2(H_TOTAL);
  localparam int VC_W        = $clog2(V_TOTAL);
  localparam int GROUP_PIX   = 4 * DATA_W;          // two words, each pixel doubled
  localparam int PH_W        = $clog2(GROUP_PIX);
  localparam int SLOT_LEN    = GROUP_PIX / 2;       // processor window, then video window
  localparam int GROUPS      = H_VIS / GROUP_PIX;
  localparam int LAST_PERIOD = H_TOTAL / GROUP_PIX - 1;
  localparam int ROW_WORDS   = SRC_W / DATA_W;
  localparam int TOP         = (V_VIS - 2 * SRC_H) / 2;
  localparam int HS_START    = H_VIS + H_FP;
  localparam int VS_START    = V_VIS + V_FP;

  logic [HC_W-1:0] hCount;
  logic [VC_W-1:0] vCount;

  always_ff @(posedge clk) begin
    if (rst) begin
      hCount <= '0;
      vCount <= '0;
    end else if (int'(hCount) == H_TOTAL - 1) begin
      hCount <= '0;
      vCount <= (int'(vCount) == V_TOTAL - 1) ? '0 : vCount + 1'b1;
    end else begin
      hCount <= hCount + 1'b1;
    end
  end

  function automatic logic lineShown(input int line);
    return (line >= TOP) && (line < TOP + 2 * SRC_H);
  endfunction

  logic rdFirst, rdSecond;

  always_comb begin
    int hI, vI, phase, period, fetchLine, fetchGroup, row;
    logic want;
    hI     = int'(hCount);
    vI     = int'(vCount);
    phase  = hI % GROUP_PIX;
    period = hI / GROUP_PIX;
    if (period == LAST_PERIOD) begin
      fetchLine  = (vI == V_TOTAL - 1) ? 0 : vI + 1;
      fetchGroup = 0;
      want       = 1'b1;
    end else begin
      fetchLine  = vI;
      fetchGroup = period + 1;
      want       = (period < GROUPS - 1);
    end
    want     = want && lineShown(fetchLine);
    row      = (fetchLine - TOP) / 2;
    rdFirst  = want && (phase == SLOT_LEN);
    rdSecond = want && (phase == SLOT_LEN + 1);
    ramRd    = rdFirst || rdSecond;
    ramAddr  = ramRd ? ADDR_W'(row * ROW_WORDS + 2 * fetchGroup + (rdSecond ? 1 : 0))
                     : '0;
    cpuSlot  = (phase < SLOT_LEN);

    strb.loadBuf  = (phase == 0);
    strb.shiftBuf = (phase % 2) == 1;
    strb.pixOn    = (hI < H_VIS) && lineShown(vI);
    strb.hsyncN   = !((hI >= HS_START) && (hI < HS_START + H_SYNC));
    strb.vsyncN   = !((vI >= VS_START) && (vI < VS_START + V_SYNC));
  end

  // RAM data arrives one clock after each read strobe.
  logic capHiQ, capLoQ;
  always_ff @(posedge clk) begin
    if (rst) begin
      capHiQ <= 1'b0;
      capLoQ <= 1'b0;
    end else begin
      capHiQ <= rdFirst;
      capLoQ <= rdSecond;
    end
  end
  assign strb.capHi = capHiQ;
  assign strb.capLo = capLoQ;

  assert_line_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (int'(hCount) == H_TOTAL - 1) |=> (hCount == '0));

  assert_frame_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    ((int'(hCount) == H_TOTAL - 1) && (int'(vCount) == V_TOTAL - 1)) |=> (vCount == '0));

  assert_no_read_in_cpu_slot_R3: assert property (@(posedge clk) disable iff (rst)
    ramRd |-> !cpuSlot);

  assert_read_pair_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(ramRd) |=> (ramRd && (ramAddr == $past(ramAddr) + ADDR_W'(1))));

  assert_read_pair_end_R4: assert property (@(posedge clk) disable iff (rst)
    (ramRd && $past(ramRd)) |=> !ramRd);

endmodule

// File: rtl/scanData.sv
module scanData
  import monoScanoutPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strb,
  input  logic [DATA_W-1:0] ramData,
  output logic              hsyncN,
  output logic              vsyncN,
  output logic              videoOut
);

  localparam int BUF_W = 2 * DATA_W;

  logic [BUF_W-1:0] fetchBuf;
  logic [BUF_W-1:0] shifter;
  logic             curBit;

  always_ff @(posedge clk) begin
    if (rst) begin
      fetchBuf <= '0;
    end else begin
      if (strb.capHi) fetchBuf[BUF_W-1:DATA_W] <= ramData;
      if (strb.capLo) fetchBuf[DATA_W-1:0]     <= ramData;
    end
  end

  assign curBit = strb.loadBuf ? fetchBuf[BUF_W-1] : shifter[BUF_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      shifter <= '0;
    end else if (strb.loadBuf) begin
      shifter <= fetchBuf;
    end else if (strb.shiftBuf) begin
      shifter <= {shifter[BUF_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hsyncN   <= 1'b1;
      vsyncN   <= 1'b1;
      videoOut <= 1'b0;
    end else begin
      hsyncN   <= strb.hsyncN;
      vsyncN   <= strb.vsyncN;
      videoOut <= strb.pixOn & ~curBit;
    end
  end

  assert_blank_black_R9: assert property (@(posedge clk) disable iff (rst)
    !strb.pixOn |=> !videoOut);

  assert_fetch_order_R4: assert property (@(posedge clk) disable iff (rst)
    strb.capLo |-> $past(strb.capHi));

endmodule

// File: rtl/monoScanout.sv
module monoScanout
  import monoScanoutPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 14,
  parameter int SRC_W  = 512,
  parameter int SRC_H  = 342,
  parameter int H_VIS  = 1024,
  parameter int H_FP   = 24,
  parameter int H_SYNC = 136,
  parameter int H_BP   = 160,
  parameter int V_VIS  = 768,
  parameter int V_FP   = 3,
  parameter int V_SYNC = 6,
  parameter int V_BP   = 29
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] ramData,
  output logic              ramRd,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              cpuSlot,
  output logic              hsyncN,
  output logic              vsyncN,
  output logic              videoOut
);

  ctrlStrobes_t strb;

  scanCtrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SRC_W(SRC_W), .SRC_H(SRC_H),
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) uCtrl (
    .clk(clk), .rst(rst), .ramRd(ramRd), .ramAddr(ramAddr),
    .cpuSlot(cpuSlot), .strb(strb)
  );

  scanData #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rst(rst), .strb(strb), .ramData(ramData),
    .hsyncN(hsyncN), .vsyncN(vsyncN), .videoOut(videoOut)
  );

endmodule

// File: tb/monoScanout_test.sv
module monoScanout_test;

  localparam int CLK_PERIOD = 16;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 14;
  localparam int SRC_W  = 512;
  localparam int SRC_H  = 6;
  localparam int H_VIS = 1024, H_FP = 24, H_SYNC = 136, H_BP = 160;
  localparam int V_VIS = 20,   V_FP = 2,  V_SYNC = 3,   V_BP = 4;
  localparam int H_TOTAL = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int FRAME   = H_TOTAL * V_TOTAL;
  localparam int TOP     = (V_VIS - 2 * SRC_H) / 2;
  localparam int NSAMP   = 4 * FRAME + 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DATA_W-1:0] ramData = '0;
  logic ramRd, cpuSlot, hsyncN, vsyncN, videoOut;
  logic [ADDR_W-1:0] ramAddr;

  int checks = 0;
  int errors = 0;
  int mode = 0;
  logic [31:0] seed;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  monoScanout #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SRC_W(SRC_W), .SRC_H(SRC_H),
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) uut (
    .clk(clk), .rst(rst), .ramData(ramData), .ramRd(ramRd), .ramAddr(ramAddr),
    .cpuSlot(cpuSlot), .hsyncN(hsyncN), .vsyncN(vsyncN), .videoOut(videoOut)
  );

  function automatic logic [15:0] patWord(input int a);
    logic [31:0] h;
    case (mode)
      0:       begin h = (a * 32'h9E3779B1) ^ seed; return h[22:7]; end
      1:       return 16'h8001;
      2:       return 16'(a) ^ 16'h5A00;
      default: return 16'h0000;
    endcase
  endfunction

  // RAM model: one clock of read latency.
  always @(posedge clk) if (ramRd) ramData <= patWord(int'(ramAddr));

  function automatic bit shown(input int line);
    return (line >= TOP) && (line < TOP + 2 * SRC_H);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    chk(0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    int rdCount = 0;
    int frameNo = 0;
    seed = $urandom(32'd4242);
    seed = $urandom;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk(hsyncN == 1'b1,   "R10 hsyncN", hsyncN, 1);
    chk(vsyncN == 1'b1,   "R10 vsyncN", vsyncN, 1);
    chk(videoOut == 1'b0, "R10 videoOut", videoOut, 0);
    chk(ramRd == 1'b0,    "R10 ramRd", ramRd, 0);
    chk(cpuSlot == 1'b1,  "R10 cpuSlot", cpuSlot, 1);
    rst = 1'b0;
    for (int k = 1; k <= NSAMP; k++) begin
      int pos, v, c, ph, per, pv, pc, fl, fg, expAddr, expReads;
      bit expRd, expVid;
      @(posedge clk);
      @(negedge clk);
      pos = k % FRAME;  v = pos / H_TOTAL;  c = pos % H_TOTAL;
      ph = c % 64;      per = c / 64;
      // R3 processor window
      chk(cpuSlot == (ph < 32), "R3 cpuSlot", cpuSlot, ph < 32);
      // R4 read strobe position and prefetch
      if (per == H_TOTAL / 64 - 1) begin
        fl = (v == V_TOTAL - 1) ? 0 : v + 1;  fg = 0;
        expRd = (ph == 32 || ph == 33) && shown(fl);
      end else begin
        fl = v;  fg = per + 1;
        expRd = (ph == 32 || ph == 33) && (per < H_VIS / 64 - 1) && shown(fl);
      end
      chk(ramRd == expRd, "R4 ramRd", ramRd, expRd);
      if (ramRd && expRd) begin
        expAddr = ((fl - TOP) / 2) * (SRC_W / 16) + 2 * fg + (ph - 32);
        chk(int'(ramAddr) == expAddr, "R6 ramAddr", int'(ramAddr), expAddr);
      end
      if (ramRd) rdCount++;
      if (c == H_TOTAL - 1) begin
        expReads = (shown(v) ? 30 : 0) + (shown((v + 1) % V_TOTAL) ? 2 : 0);
        chk(rdCount == expReads, "R5 reads per line", rdCount, expReads);
        rdCount = 0;
      end
      // registered raster outputs show the previous column
      pv = ((k - 1) % FRAME) / H_TOTAL;
      pc = ((k - 1) % FRAME) % H_TOTAL;
      chk(hsyncN == !(pc >= H_VIS + H_FP && pc < H_VIS + H_FP + H_SYNC),
          "R1 hsyncN", hsyncN, !(pc >= H_VIS + H_FP && pc < H_VIS + H_FP + H_SYNC));
      chk(vsyncN == !(pv >= V_VIS + V_FP && pv < V_VIS + V_FP + V_SYNC),
          "R2 vsyncN", vsyncN, !(pv >= V_VIS + V_FP && pv < V_VIS + V_FP + V_SYNC));
      if (pc >= H_VIS || pv >= V_VIS) begin
        chk(videoOut == 1'b0, "R9 blanking", videoOut, 0);
      end else if (!shown(pv)) begin
        chk(videoOut == 1'b0, "R8 letterbox", videoOut, 0);
      end else begin
        int row, col, w;
        logic [15:0] d;
        row = (pv - TOP) / 2;  col = pc / 2;
        w = row * (SRC_W / 16) + col / 16;
        d = patWord(w);
        expVid = !d[15 - (col % 16)];
        chk(videoOut == expVid, "R7 pixel", videoOut, expVid);
      end
      // new pattern once the image region of this frame is over
      if (v == V_VIS + 1 && c == 0) begin
        frameNo++;
        mode = frameNo % 4;
        seed = $urandom;
      end
    end
    finishRun();
  end

endmodule